// File: doc/BRIEF.md
# Per-Branch History Direction Predictor

This block guesses whether a conditional branch will be taken by looking at how that same branch behaved on its last few executions. A field of the branch address selects one entry in a first-level table of shift registers. Each shift register holds the recent taken/not-taken pattern of the branches that map to it. That pattern alone then selects one saturating counter in a second-level table, and the upper half of the counter range means "taken".

A fetch stage raises a lookup request with the branch address and gets the direction one clock later. When the branch resolves, the back end presents the address and the real outcome on the training port. In that same clock the counter chosen by the current pattern moves one step toward the outcome, and the outcome is shifted into the pattern. The pattern width, first-level depth, counter width and address field position are all parameters.

Top module: `local_hist_predictor`

## Requirements
- R1: Synchronous active-high reset clears every history entry to zero and sets every counter to the weakly not-taken value 2^(CTR_W-1)-1 (1 for the default 2-bit counter). `pred_vld` is low during reset and in the first cycle after it, and any lookup made right after reset returns not-taken.
- R2: `pred_vld` is high in exactly the cycles that follow a clock edge at which `pred_req` was high.
- R3: With `pred_vld` high, `pred_taken` is 1 when the counter selected by the history entry of the requested address is at least 2^(CTR_W-1), that is, when its most significant bit is set.
- R4: A training request with `upd_taken`=1 raises the counter selected by the entry's history as it stood before the update by one. With `upd_taken`=0 it lowers that counter by one.
- R5: Counters saturate at 0 and at 2^CTR_W-1. Training past either end leaves the counter unchanged and never wraps.
- R6: Training shifts the outcome into the selected history entry at bit 0. The older bits move one place up and the oldest bit is dropped, so the new value is {old[HIST_W-2:0], upd_taken}.
- R7: Both ports select the history entry with address bits [PC_LSB+IDX_W-1:PC_LSB], which is bits [9:2] by default. Addresses that differ only outside that field share one entry.
- R8: When a lookup and a training request arrive at the same clock edge, the lookup result reflects the tables as they were before that training took effect.
- R9: A training request changes only one history entry and one counter. Lookups through any other entry or pattern return what they did before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_req | input | 1 | Lookup request |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_vld | output | 1 | Registered: lookup result valid |
| pred_taken | output | 1 | Registered: predicted direction, 1 = taken |
| upd_en | input | 1 | Training request |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A wrong history entry shows up at the ports only indirectly. It sends the next lookup of that branch to the wrong counter, so a single bad shift can stay hidden until the mistaken pattern lands on a counter whose upper bit differs from the correct one, and that can take several executions of the branch. A counter that wraps instead of saturating flips the predicted direction at once on the next lookup that reaches it. This is why long runs of one outcome are driven on purpose. The bench mirrors both tables and compares every lookup one cycle after the request, so a divergence appears within one lookup of the first pattern where it matters.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  typedef enum logic {
    LHP_NOT_TAKEN = 1'b0,
    LHP_TAKEN     = 1'b1
  } lhp_dir_e;

  localparam int LHP_DEF_PC_W   = 32;
  localparam int LHP_DEF_PC_LSB = 2;
  localparam int LHP_DEF_IDX_W  = 8;
  localparam int LHP_DEF_HIST_W = 8;
  localparam int LHP_DEF_CTR_W  = 2;

endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [HIST_W-1:0] rd_a_hist,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [HIST_W-1:0] rd_b_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [HIST_W-1:0] wr_hist
);

  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) hist_mem[i] <= '0;
    end else if (wr_en) begin
      hist_mem[wr_idx] <= wr_hist;
    end
  end

  assign rd_a_hist = hist_mem[rd_a_idx];
  assign rd_b_hist = hist_mem[rd_b_idx];

endmodule

// File: rtl/lhp_ctr_table.sv
module lhp_ctr_table #(
  parameter int HIST_W = 8,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HIST_W-1:0] rd_a_pat,
  output logic [CTR_W-1:0]  rd_a_ctr,
  input  logic [HIST_W-1:0] rd_b_pat,
  output logic [CTR_W-1:0]  rd_b_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_pat,
  input  logic [CTR_W-1:0]  wr_ctr
);

  localparam int DEPTH = 1 << HIST_W;
  localparam logic [CTR_W-1:0] WEAK_NT = {1'b0, {(CTR_W-1){1'b1}}};

  logic [CTR_W-1:0] ctr_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_mem[i] <= WEAK_NT;
    end else if (wr_en) begin
      ctr_mem[wr_pat] <= wr_ctr;
    end
  end

  assign rd_a_ctr = ctr_mem[rd_a_pat];
  assign rd_b_ctr = ctr_mem[rd_b_pat];

endmodule

// File: rtl/lhp_ctr_step.sv
module lhp_ctr_step
  import lhp_pkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur,
  input  lhp_dir_e         dir,
  output logic [CTR_W-1:0] nxt
);

  localparam logic [CTR_W-1:0] TOP = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] ONE = {{(CTR_W-1){1'b0}}, 1'b1};

  always_comb begin
    nxt = cur;
    if (dir == LHP_TAKEN) begin
      if (cur != TOP) nxt = cur + ONE;
    end else begin
      if (cur != '0) nxt = cur - ONE;
    end
  end

endmodule

// File: rtl/local_hist_predictor.sv
module local_hist_predictor
  import lhp_pkg::*;
#(
  parameter int PC_W   = LHP_DEF_PC_W,
  parameter int PC_LSB = LHP_DEF_PC_LSB,
  parameter int IDX_W  = LHP_DEF_IDX_W,
  parameter int HIST_W = LHP_DEF_HIST_W,
  parameter int CTR_W  = LHP_DEF_CTR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pred_req,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_vld,
  output logic            pred_taken,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam int IDX_HI = PC_LSB + IDX_W;

  logic [IDX_W-1:0]  pred_idx;
  logic [IDX_W-1:0]  upd_idx;
  logic [HIST_W-1:0] pred_hist;
  logic [HIST_W-1:0] upd_hist_cur;
  logic [HIST_W-1:0] upd_hist_nxt;
  logic [CTR_W-1:0]  pred_ctr;
  logic [CTR_W-1:0]  upd_ctr_cur;
  logic [CTR_W-1:0]  upd_ctr_nxt;
  lhp_dir_e          upd_dir;

  assign pred_idx = pred_pc[PC_LSB +: IDX_W];
  assign upd_idx  = upd_pc[PC_LSB +: IDX_W];
  assign upd_dir  = upd_taken ? LHP_TAKEN : LHP_NOT_TAKEN;

  // Address bits outside the index field do not take part (R7).
  generate
    if (PC_LSB > 0 && IDX_HI < PC_W) begin : g_both_sides
      logic unused_pc_bits;
      assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_HI], pred_pc[PC_LSB-1:0],
                                upd_pc[PC_W-1:IDX_HI], upd_pc[PC_LSB-1:0]};
    end else if (IDX_HI < PC_W) begin : g_high_only
      logic unused_pc_bits;
      assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_HI], upd_pc[PC_W-1:IDX_HI]};
    end else if (PC_LSB > 0) begin : g_low_only
      logic unused_pc_bits;
      assign unused_pc_bits = ^{pred_pc[PC_LSB-1:0], upd_pc[PC_LSB-1:0]};
    end
  endgenerate

  lhp_hist_table #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W)
  ) u_hist (
    .clk       (clk),
    .rst       (rst),
    .rd_a_idx  (pred_idx),
    .rd_a_hist (pred_hist),
    .rd_b_idx  (upd_idx),
    .rd_b_hist (upd_hist_cur),
    .wr_en     (upd_en),
    .wr_idx    (upd_idx),
    .wr_hist   (upd_hist_nxt)
  );

  // Newest outcome enters at bit 0 (R6).
  assign upd_hist_nxt = {upd_hist_cur[HIST_W-2:0], upd_taken};

  lhp_ctr_table #(
    .HIST_W (HIST_W),
    .CTR_W  (CTR_W)
  ) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .rd_a_pat (pred_hist),
    .rd_a_ctr (pred_ctr),
    .rd_b_pat (upd_hist_cur),
    .rd_b_ctr (upd_ctr_cur),
    .wr_en    (upd_en),
    .wr_pat   (upd_hist_cur),
    .wr_ctr   (upd_ctr_nxt)
  );

  lhp_ctr_step #(
    .CTR_W (CTR_W)
  ) u_step (
    .cur (upd_ctr_cur),
    .dir (upd_dir),
    .nxt (upd_ctr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_vld   <= 1'b0;
      pred_taken <= 1'b0;
    end else begin
      pred_vld   <= pred_req;
      pred_taken <= pred_req & pred_ctr[CTR_W-1];
    end
  end

endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
  parameter int HIST_W = 8,
  parameter int CTR_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pred_req,
  input logic              pred_vld,
  input logic              upd_en,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist_rd,
  input logic [HIST_W-1:0] hist_wr,
  input logic [CTR_W-1:0]  ctr_rd,
  input logic [CTR_W-1:0]  ctr_wr
);

  localparam logic [CTR_W-1:0] TOP = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] ONE = {{(CTR_W-1){1'b0}}, 1'b1};

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pred_vld);

  assert_vld_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    pred_req |=> pred_vld);

  assert_vld_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !pred_req |=> !pred_vld);

  assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_taken && ctr_rd != TOP) |-> ctr_wr == ctr_rd + ONE);

  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_taken && ctr_rd != '0) |-> ctr_wr == ctr_rd - ONE);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_taken && ctr_rd == TOP) |-> ctr_wr == TOP);

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_taken && ctr_rd == '0) |-> ctr_wr == '0);

  assert_shift_in_R6: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> (hist_wr[0] == upd_taken) && (hist_wr[HIST_W-1:1] == hist_rd[HIST_W-2:0]));

endmodule

bind local_hist_predictor lhp_checker #(
  .HIST_W (HIST_W),
  .CTR_W  (CTR_W)
) u_lhp_checker (
  .clk       (clk),
  .rst       (rst),
  .pred_req  (pred_req),
  .pred_vld  (pred_vld),
  .upd_en    (upd_en),
  .upd_taken (upd_taken),
  .hist_rd   (upd_hist_cur),
  .hist_wr   (upd_hist_nxt),
  .ctr_rd    (upd_ctr_cur),
  .ctr_wr    (upd_ctr_nxt)
);

// File: tb/test_local_hist_predictor.sv
`timescale 1ns/1ps
module test_local_hist_predictor;

  localparam int PC_W = 32;
  localparam int IDX_N = 256;
  localparam int HIST_N = 256;
  localparam int CTR_MAX = 3;
  localparam int WEAK_NT = 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            pred_req = 1'b0;
  logic [PC_W-1:0] pred_pc = '0;
  logic            pred_vld;
  logic            pred_taken;
  logic            upd_en = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;

  int checks = 0;
  int failures = 0;
  int m_hist [IDX_N];
  int m_ctr  [HIST_N];

  always #4 clk = ~clk;

  local_hist_predictor i_local_hist_predictor (
    .clk        (clk),
    .rst        (rst),
    .pred_req   (pred_req),
    .pred_pc    (pred_pc),
    .pred_vld   (pred_vld),
    .pred_taken (pred_taken),
    .upd_en     (upd_en),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken)
  );

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return int'((pc >> 2) & 32'hFF);
  endfunction

  function automatic logic exp_pred(input logic [PC_W-1:0] pc);
    return m_ctr[m_hist[idx_of(pc)]] >= 2;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < IDX_N; i++) m_hist[i] = 0;
    for (int i = 0; i < HIST_N; i++) m_ctr[i] = WEAK_NT;
  endfunction

  function automatic void model_train(input logic [PC_W-1:0] pc, input logic t);
    int ix = idx_of(pc);
    int h = m_hist[ix];
    if (t && m_ctr[h] < CTR_MAX) m_ctr[h] = m_ctr[h] + 1;
    if (!t && m_ctr[h] > 0) m_ctr[h] = m_ctr[h] - 1;
    m_hist[ix] = ((h << 1) | int'(t)) & 8'hFF;
  endfunction

  task automatic check(input string req, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, expv);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic step(input string req, input logic pr, input logic [PC_W-1:0] ppc,
                      input logic ue, input logic [PC_W-1:0] upc, input logic ut);
    logic e;
    pred_req  = pr;
    pred_pc   = ppc;
    upd_en    = ue;
    upd_pc    = upc;
    upd_taken = ut;
    e = exp_pred(ppc);
    if (ue) model_train(upc, ut);
    @(posedge clk);
    @(negedge clk);
    pred_req = 1'b0;
    upd_en   = 1'b0;
    check("R2", pred_vld, pr, "pred_vld");
    if (pr) check(req, pred_taken, e, "pred_taken");
  endtask

  task automatic predict(input string req, input logic [PC_W-1:0] pc);
    step(req, 1'b1, pc, 1'b0, '0, 1'b0);
  endtask

  task automatic train(input string req, input logic [PC_W-1:0] pc, input logic t);
    step(req, 1'b0, '0, 1'b1, pc, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] pa, pb, pc_alias;
    int unsigned seed;
    seed = $urandom(32'h0C0FFEE5);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", pred_vld, 1'b0, "pred_vld after reset");

    // R1: fresh tables predict not-taken everywhere
    predict("R1", 32'h0000_0000);
    predict("R1", 32'h0000_03FC);
    predict("R1", 32'h1234_5678);

    // R5: long not-taken run drives counter 0 to floor, no wrap
    pa = 32'h0000_0040;
    for (int i = 0; i < 6; i++) train("R5", pa, 1'b0);
    predict("R5", pa);
    // R4/R5: long taken run fills history, then counter 0xFF saturates high
    for (int i = 0; i < 14; i++) train("R4", pa, 1'b1);
    predict("R5", pa);
    train("R4", pa, 1'b1);
    predict("R5", pa);
    check("R5", pred_taken, 1'b1, "saturated counter stays taken");

    // R6: alternating pattern is learned through history
    pb = 32'h0000_0100;
    for (int i = 0; i < 24; i++) begin
      predict("R6", pb);
      train("R6", pb, 1'(i % 2));
    end

    // R7: alias differing above bit 9 and in bits 1:0 shares the entry
    pc_alias = pa + 32'h0000_0400 + 32'h3;
    predict("R7", pc_alias);
    check("R7", pred_taken, 1'b1, "alias sees trained entry");
    train("R7", pc_alias, 1'b0);
    predict("R7", pa);

    // R9: training a different entry leaves pb untouched
    predict("R9", pb);
    train("R9", 32'h0000_0200, 1'b1);
    predict("R9", pb);

    // R8: same-edge lookup and training sees pre-update state
    for (int i = 0; i < 8; i++) train("R8", 32'h0000_0300, 1'b1);
    step("R8", 1'b1, 32'h0000_0300, 1'b1, 32'h0000_0300, 1'b0);
    step("R8", 1'b1, 32'h0000_0300, 1'b1, 32'h0000_0300, 1'b1);
    predict("R8", 32'h0000_0300);

    // R3: random mix over a small branch set with biased outcomes
    for (int n = 0; n < 3000; n++) begin
      int unsigned r = $urandom;
      logic [PC_W-1:0] p1 = {20'(r >> 12), 10'((r % 6) << 2), 2'b00};
      logic [PC_W-1:0] p2 = {20'(r >> 8), 10'(((r >> 4) % 6) << 2), 2'b00};
      logic t = ((r >> 20) % 4) != 0 ? ((r % 6) < 3) : 1'(r >> 24);
      step("R3", 1'((r >> 3) & 1), p1, 1'((r >> 5) & 1), p2, t);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule